// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives one open-drain data line that a pull-up holds high when nobody pulls it. It carries out one bus operation per request: a bus reset that also listens for a device answering, the write of one bit, or the read of one bit. The caller puts an operation code and a bit value on the request port while `req_valid` is high. The block then raises `busy` and runs the timed sequence on the line. When the sequence is over it gives a one-clock `done` pulse. After that pulse the device-present flag or the read bit holds the result of the operation.

The line is handled in two parts. `bus_pull` is an output enable: when it is 1 the external pad drives the line to ground, and when it is 0 the line floats. `bus_in` is the level on the line, and it passes through a two-flop synchronizer before any sample is taken. All timing is counted in microseconds. A prescaler turns `CLKS_PER_US` system clocks into one microsecond. Every pulse width and every sample point is a microsecond parameter. Grouping bits into bytes, sending device commands and checking data integrity are left to the logic around the block.

Top module: `owb_master`

## Requirements
- R1: After `rst_n` is low, all of `busy`, `done`, `bus_pull`, `presence` and `rd_bit` read 0.
- R2: A reset request (`req_op` = 2'b01) drives `bus_pull` high for exactly RST_LOW_US×CLKS_PER_US clocks, starting the clock after it is accepted. `done` rises (RST_LOW_US+RST_RX_US)×CLKS_PER_US+1 clocks after acceptance.
- R3: A reset sets `presence` to 1 when the line is low PRES_SAMPLE_US after the release, and to 0 when the line is high at that point.
- R4: A write request (`req_op` = 2'b10) drives `bus_pull` for W1_LOW_US×CLKS_PER_US clocks when `req_bit` is 1, and for W0_LOW_US×CLKS_PER_US clocks when it is 0. A device that samples the line 30 µs after the falling edge sees `req_bit`.
- R5: A write or a read raises `done` (SLOT_US+REC_US)×CLKS_PER_US+1 clocks after acceptance. This covers the slot and the recovery time that follows it.
- R6: A read request (`req_op` = 2'b11) drives `bus_pull` for RD_LOW_US×CLKS_PER_US clocks. `rd_bit` becomes the synchronized line level at RD_SAMPLE_US: 1 for high, 0 for low.
- R7: `busy` is high from the clock after acceptance until `done`. A request made while `busy` is high has no effect on the line, on the timing or on the results.
- R8: `done` is high for exactly one clock, and `busy` is already low in that clock.
- R9: A request with `req_op` = 2'b00 is ignored: `busy` and `bus_pull` stay low.
- R10: Only a reset changes `presence`, and only a read changes `rd_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 none, 01 reset, 10 write, 11 read |
| req_bit | input | 1 | Bit value for a write |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-clock pulse when an operation ends |
| presence | output | 1 | A device answered the last reset |
| rd_bit | output | 1 | Bit taken by the last read |
| bus_pull | output | 1 | 1 pulls the line low |
| bus_in | input | 1 | Level on the line |

## Verification
The assertions assume that `bus_in` only ever sees the line as the block and the device model leave it. They also assume that requests arrive as plain strobes, which the block may accept or drop. The bench keeps within this with a device model that answers the way a real device would. Its presence pulse starts 15 to 60 µs after the release and lasts 60 to 240 µs. It holds a read-0 for 15 µs from the falling edge, and it samples writes at 30 µs. No device edge therefore falls near a sample point of the block. The random stimulus chooses the operation, the bit, whether a device is present and the pulse delays only inside those ranges.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owb_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } owb_state_e;

    typedef struct packed {
        owb_state_e state;
        owb_op_e    op;
        logic       wbit;
        logic       done;
        logic       presence;
        logic       rd_bit;
    } owb_ctrl_t;

    function automatic int owb_width(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/owb_us_timer.sv
module owb_us_timer
    import owb_pkg::*;
#(
    parameter int CLKS_PER_US = 250,
    parameter int US_W        = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    output logic [US_W-1:0] us,
    output logic            us_edge
);
    localparam int              PRE_W    = owb_width(CLKS_PER_US - 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [US_W-1:0]  us_d, us_q;

    always_comb begin
        pre_d = pre_q;
        us_d  = us_q;
        if (clear) begin
            pre_d = '0;
            us_d  = '0;
        end else if (run) begin
            if (pre_q == PRE_LAST) begin
                pre_d = '0;
                us_d  = us_q + 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else begin
            pre_q <= pre_d;
            us_q  <= us_d;
        end
    end

    assign us      = us_q;
    assign us_edge = (pre_q == '0);

    // The prescaler never passes its terminal count (microsecond grid, R2)
    assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);

    // A cleared timer restarts from zero on the next clock (R7)
    assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (us_q == '0 && pre_q == '0));
endmodule

// File: rtl/owb_slot_ctrl.sv
module owb_slot_ctrl
    import owb_pkg::*;
#(
    parameter int US_W           = 10,
    parameter int RST_LOW_US     = 480,
    parameter int RST_RX_US      = 480,
    parameter int PRES_SAMPLE_US = 70,
    parameter int W1_LOW_US      = 6,
    parameter int W0_LOW_US      = 60,
    parameter int RD_LOW_US      = 3,
    parameter int RD_SAMPLE_US   = 13,
    parameter int SLOT_US        = 65,
    parameter int REC_US         = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic            req_bit,
    input  logic [US_W-1:0] us,
    input  logic            us_edge,
    input  logic            line_sync,
    output logic            timer_clear,
    output logic            timer_run,
    output logic            busy,
    output logic            done,
    output logic            presence,
    output logic            rd_bit,
    output logic            pull
);
    localparam logic [US_W-1:0] RST_END  = US_W'(RST_LOW_US + RST_RX_US);
    localparam logic [US_W-1:0] SLOT_END = US_W'(SLOT_US + REC_US);
    localparam logic [US_W-1:0] PRES_AT  = US_W'(RST_LOW_US + PRES_SAMPLE_US);
    localparam logic [US_W-1:0] RD_AT    = US_W'(RD_SAMPLE_US);
    localparam logic [US_W-1:0] RST_LOW  = US_W'(RST_LOW_US);
    localparam logic [US_W-1:0] W1_LOW   = US_W'(W1_LOW_US);
    localparam logic [US_W-1:0] W0_LOW   = US_W'(W0_LOW_US);
    localparam logic [US_W-1:0] RD_LOW   = US_W'(RD_LOW_US);

    owb_ctrl_t ctl_d, ctl_q;
    logic [US_W-1:0] low_us, end_us;
    logic accept;

    always_comb begin
        unique case (ctl_q.op)
            OP_RESET: begin low_us = RST_LOW; end_us = RST_END;  end
            OP_WRITE: begin low_us = ctl_q.wbit ? W1_LOW : W0_LOW; end_us = SLOT_END; end
            OP_READ:  begin low_us = RD_LOW;  end_us = SLOT_END; end
            default:  begin low_us = '0;      end_us = '0;       end
        endcase
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        accept      = (ctl_q.state == ST_IDLE) && req_valid && (req_op != OP_NONE);
        timer_clear = accept;
        if (accept) begin
            ctl_d.state = ST_RUN;
            ctl_d.op    = owb_op_e'(req_op);
            ctl_d.wbit  = req_bit;
        end else if (ctl_q.state == ST_RUN && us_edge) begin
            if (ctl_q.op == OP_RESET && us == PRES_AT) ctl_d.presence = !line_sync;
            if (ctl_q.op == OP_READ && us == RD_AT)    ctl_d.rd_bit   = line_sync;
            if (us == end_us) begin
                ctl_d.state = ST_IDLE;
                ctl_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, op: OP_NONE, wbit: 1'b0,
                       done: 1'b0, presence: 1'b0, rd_bit: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign timer_run = (ctl_q.state == ST_RUN);
    assign busy      = (ctl_q.state == ST_RUN);
    assign done      = ctl_q.done;
    assign presence  = ctl_q.presence;
    assign rd_bit    = ctl_q.rd_bit;
    assign pull      = (ctl_q.state == ST_RUN) && (us < low_us);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_op_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(ctl_q.op));

    assert_pull_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> busy);

    assert_us_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (us <= end_us));

    assert_presence_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.op != OP_RESET) |=> $stable(presence));

    assert_rdbit_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.op != OP_READ) |=> $stable(rd_bit));
endmodule

// File: rtl/owb_master.sv
module owb_master
    import owb_pkg::*;
#(
    parameter int CLKS_PER_US    = 250,
    parameter int RST_LOW_US     = 480,
    parameter int RST_RX_US      = 480,
    parameter int PRES_SAMPLE_US = 70,
    parameter int W1_LOW_US      = 6,
    parameter int W0_LOW_US      = 60,
    parameter int RD_LOW_US      = 3,
    parameter int RD_SAMPLE_US   = 13,
    parameter int SLOT_US        = 65,
    parameter int REC_US         = 5,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_bit,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rd_bit,
    output logic       bus_pull,
    input  logic       bus_in
);
    localparam int MAX_US = (RST_LOW_US + RST_RX_US > SLOT_US + REC_US)
                          ? RST_LOW_US + RST_RX_US : SLOT_US + REC_US;
    localparam int US_W   = owb_width(MAX_US + 1);

    logic            line_sync;
    logic            timer_clear, timer_run, us_edge;
    logic [US_W-1:0] us;

    owb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bus_in),
        .q_out (line_sync)
    );

    owb_us_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .run     (timer_run),
        .us      (us),
        .us_edge (us_edge)
    );

    owb_slot_ctrl #(
        .US_W(US_W), .RST_LOW_US(RST_LOW_US), .RST_RX_US(RST_RX_US),
        .PRES_SAMPLE_US(PRES_SAMPLE_US), .W1_LOW_US(W1_LOW_US),
        .W0_LOW_US(W0_LOW_US), .RD_LOW_US(RD_LOW_US),
        .RD_SAMPLE_US(RD_SAMPLE_US), .SLOT_US(SLOT_US), .REC_US(REC_US)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_bit     (req_bit),
        .us          (us),
        .us_edge     (us_edge),
        .line_sync   (line_sync),
        .timer_clear (timer_clear),
        .timer_run   (timer_run),
        .busy        (busy),
        .done        (done),
        .presence    (presence),
        .rd_bit      (rd_bit),
        .pull        (bus_pull)
    );

    // An operation can only end after running (R8)
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // Idle block leaves the line released (R9)
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_pull);
endmodule

// File: tb/owb_master_test.sv
`timescale 1ns/1ps
module owb_master_test;
    localparam int CPU = 4;
    localparam int RST_LOW = 480, RST_RX = 480, PRES_AT = 70;
    localparam int W1 = 6, W0 = 60, RDL = 3, SLOT = 65, REC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic req_bit = 1'b0;
    logic busy, done, presence, rd_bit, bus_pull, bus_in;

    int n_checks = 0;
    int n_fail = 0;

    // device model state
    logic dev_pull = 1'b0;
    logic prev_pull = 1'b0;
    int   fall_cnt = 1000000;
    logic [1:0] dev_mode = 2'b00;
    logic dev_present = 1'b0;
    logic dev_rd_val = 1'b1;
    logic dev_cap = 1'b0;
    int   pres_dly = 30, pres_w = 120;

    always #2 clk = ~clk;

    assign bus_in = !(bus_pull || dev_pull);

    owb_master #(.CLKS_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .busy(busy), .done(done), .presence(presence),
        .rd_bit(rd_bit), .bus_pull(bus_pull), .bus_in(bus_in)
    );

    always @(negedge clk) begin
        if (bus_pull && !prev_pull) fall_cnt = 0;
        else if (fall_cnt < 1000000) fall_cnt = fall_cnt + 1;
        prev_pull = bus_pull;
        case (dev_mode)
            2'b11: dev_pull = !dev_rd_val && (fall_cnt < 15 * CPU);
            2'b10: begin
                dev_pull = 1'b0;
                if (fall_cnt == 30 * CPU) dev_cap = bus_in;
            end
            2'b01: dev_pull = dev_present
                              && fall_cnt >= (RST_LOW + pres_dly) * CPU
                              && fall_cnt <  (RST_LOW + pres_dly + pres_w) * CPU;
            default: dev_pull = 1'b0;
        endcase
    end

    function automatic int exp_low(input logic [1:0] op, input logic b);
        case (op)
            2'b01:   return RST_LOW * CPU;
            2'b10:   return (b ? W1 : W0) * CPU;
            2'b11:   return RDL * CPU;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cyc(input logic [1:0] op);
        return ((op == 2'b01) ? (RST_LOW + RST_RX) : (SLOT + REC)) * CPU + 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic b, input bit poke);
        int cyc, lows;
        bit gap;
        logic p_before, r_before;
        p_before = presence;
        r_before = rd_bit;
        dev_mode = op;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bit = b;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; lows = 0; gap = 0;
        while (!done && cyc < 20000) begin
            if (bus_pull) lows++;
            if (!busy) gap = 1;
            if (poke && cyc == 40) begin
                req_valid = 1'b1; req_op = 2'b01; req_bit = ~b;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (op == 2'b01) begin
            check(lows == exp_low(op, b), "R2 reset low length", lows, exp_low(op, b));
            check(cyc == exp_cyc(op), "R2 reset duration", cyc, exp_cyc(op));
            check(presence == dev_present, "R3 presence flag", presence, dev_present);
        end else begin
            check(cyc == exp_cyc(op), "R5 slot duration", cyc, exp_cyc(op));
            check(presence == p_before, "R10 presence kept", presence, p_before);
        end
        if (op == 2'b10) begin
            check(lows == exp_low(op, b), "R4 write low length", lows, exp_low(op, b));
            check(dev_cap == b, "R4 device sees bit", dev_cap, b);
            check(rd_bit == r_before, "R10 rd_bit kept", rd_bit, r_before);
        end
        if (op == 2'b11) begin
            check(lows == exp_low(op, b), "R6 read low length", lows, exp_low(op, b));
            check(rd_bit == dev_rd_val, "R6 read value", rd_bit, dev_rd_val);
        end
        check(!gap, "R7 busy held until done", gap, 0);
        check(!busy, "R8 busy low with done", busy, 0);
        @(negedge clk);
        check(!done, "R8 done single clock", done, 0);
        check(!busy && !bus_pull, "R7 poke not accepted", busy, 0);
        dev_mode = 2'b00;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_pull && !presence && !rd_bit,
              "R1 reset state", {busy, done, bus_pull, presence, rd_bit}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: no-op code ignored
        req_valid = 1'b1; req_op = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) begin
            check(!busy && !bus_pull, "R9 no-op ignored", busy, 0);
            @(negedge clk);
        end

        // directed cases
        dev_present = 1'b1; pres_dly = 60; pres_w = 60;
        run_op(2'b01, 1'b0, 1'b0);
        dev_present = 1'b0;
        run_op(2'b01, 1'b0, 1'b0);
        run_op(2'b10, 1'b1, 1'b1);
        run_op(2'b10, 1'b0, 1'b1);
        dev_rd_val = 1'b0;
        run_op(2'b11, 1'b0, 1'b1);
        dev_rd_val = 1'b1;
        run_op(2'b11, 1'b0, 1'b0);

        // constrained random mix
        for (int i = 0; i < 20; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(1, 3));
            dev_present = 1'($urandom_range(0, 1));
            dev_rd_val  = 1'($urandom_range(0, 1));
            pres_dly    = $urandom_range(15, 60);
            pres_w      = $urandom_range(60, 240);
            run_op(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule